// File: doc/BRIEF.md
# Privileged Profiling Control Register

This block holds one 64-bit control word for a statistical profiling unit in a processor with four privilege levels, numbered 0 to 3. Each request carries the requester's current level, a read/write flag and write data. The block judges the request against a set of configuration inputs. The request then completes, is undefined, traps to level 2 or traps to level 3. On a trap the block also reports the syndrome class 0x18. Completed writes update the stored fields. Completed reads return the stored word.

The stored fields are not always what the profiling hardware should act on. The block therefore also drives a set of effective field values. These are the stored values, overridden where the surrounding configuration forces a fixed value: level 2 absent or disabled, the buffer owned by level 2, a level-3 exception-enable control, or a buffer-ownership control. Downstream profiling logic uses only these effective outputs. Taking the exception itself is left to the core.

Top module: `prof_ctl_reg`

## Requirements
- R1: Bits 63:12 and bit 2 are always stored and read as zero. Bit 7 is also held at zero when the counter-extension parameter is off.
- R2: The writable fields sit at these positions:
  - bit 11: physical-pointer enable
  - bit 10: kernel exception enable
  - bits 9:8: exception enable
  - bits 7:6: timestamp select
  - bit 5: timestamp enable
  - bit 4: physical-address enable
  - bit 3: context enable
  - bit 1: level-2 sampling enable
  - bit 0: level-0 sampling enable
- R3: The outcome is undefined (code 01) for any request while `cfg_feat_present` is 0, and for any request from level 0.
- R4: A level-1 request traps to level 2 (code 10) with class 0x18 when `cfg_nv_trap` is 1. Otherwise it is undefined.
- R5: A level-2 request is resolved in this priority order:
  1. `cfg_l3_trap` and `cfg_undef_prio` both 1: undefined.
  2. `cfg_l3_trap` 1 and `cfg_undef_alt` 1: undefined.
  3. `cfg_l3_trap` 1 alone: trap to level 3 (code 11) with class 0x18.
  4. Otherwise: complete (code 00).
- R6: A level-3 request always completes while the feature is present.
- R7: Effective exception enable:
  - 00 when `cfg_l3_exc_ctl` is 00;
  - otherwise 01 when level 2 is absent or `cfg_secure_nol2` is 1;
  - otherwise the stored field.
- R8: Effective physical-address enable is 1 when level 2 is not both present and enabled. Effective physical-pointer enable is 1 in that case, and also when `cfg_l2_owns_buf` is 1. Otherwise both follow their stored fields.
- R9: While `cfg_own_ctl` is not 00, bits 1 and 0 read as zero and their effective values are 0.
- R10: Effective timestamp select is 01 when level 2 is not both present and enabled. A direct read still returns the stored field.
- R11: A write whose outcome is not complete leaves the stored word unchanged.
- R12: The outcome and class are valid in the cycle of the request. Read data is valid in that cycle, and is zero unless the request is a completed read. A completed write is visible from the next clock edge. After reset the stored word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lvl | input | 2 | Privilege level of the requester |
| req_wdata | input | 64 | Write data |
| cfg_feat_present | input | 1 | Profiling feature implemented |
| cfg_nv_trap | input | 1 | Low bit of the nested-virtualization control |
| cfg_l3_trap | input | 1 | Level-3 trap condition for level-2 requests |
| cfg_undef_prio | input | 1 | Undefined takes priority over the level-3 trap |
| cfg_undef_alt | input | 1 | Turns a level-3 trap into undefined |
| cfg_l3_exc_ctl | input | 2 | Level-3 exception-enable control |
| cfg_l2_present | input | 1 | Level 2 implemented |
| cfg_l2_enabled | input | 1 | Level 2 enabled in the owning security state |
| cfg_secure_nol2 | input | 1 | Secure state without level 2 selected |
| cfg_l2_owns_buf | input | 1 | Profiling buffer owned by level 2 |
| cfg_own_ctl | input | 2 | Buffer-ownership control; non-zero clears bits 1:0 |
| rsp_outcome | output | 2 | 00 complete, 01 undefined, 10 trap to 2, 11 trap to 3 |
| rsp_class | output | 6 | 0x18 on a trap, else 0 |
| rsp_rdata | output | 64 | Read data |
| eff_pptr | output | 1 | Effective physical-pointer enable |
| eff_kexc | output | 1 | Effective kernel exception enable |
| eff_exc | output | 2 | Effective exception enable |
| eff_tsel | output | 2 | Effective timestamp select |
| eff_tsen | output | 1 | Effective timestamp enable |
| eff_paen | output | 1 | Effective physical-address enable |
| eff_cxen | output | 1 | Effective context enable |
| eff_l2spe | output | 1 | Effective level-2 sampling enable |
| eff_l0spe | output | 1 | Effective level-0 sampling enable |

## Verification
The outcome, class and read data are combinational, so they are due in the request's own cycle. The monitor samples them two time units after the falling edge on which the driver presented the request. A completed write is committed at the next rising edge. The driver's model is therefore updated only for later requests, and a read in the following cycle confirms the new word. The effective outputs depend on the stored word and the configuration with no extra register. Each configuration change is checked a few time units after the falling edge on which it is applied, which is always after the last write has settled.

// File: rtl/prof_ctl_pkg.sv
package prof_ctl_pkg;
  typedef enum logic [1:0] {
    ACC_DONE  = 2'b00,
    ACC_UNDEF = 2'b01,
    ACC_TRAP2 = 2'b10,
    ACC_TRAP3 = 2'b11
  } acc_res_e;

  localparam logic [5:0] TRAP_CLASS = 6'h18;

  localparam int unsigned B_PPTR = 11;
  localparam int unsigned B_KEXC = 10;
  localparam int unsigned B_EXC  = 8;
  localparam int unsigned B_TSEL = 6;
  localparam int unsigned B_TSEN = 5;
  localparam int unsigned B_PAEN = 4;
  localparam int unsigned B_CXEN = 3;
  localparam int unsigned B_L2S  = 1;
  localparam int unsigned B_L0S  = 0;

  typedef struct packed {
    logic       pptr;
    logic       kexc;
    logic [1:0] exc;
    logic [1:0] tsel;
    logic       tsen;
    logic       paen;
    logic       cxen;
    logic       l2s;
    logic       l0s;
  } prof_fields_t;
endpackage

// File: rtl/prof_acc_chk.sv
module prof_acc_chk
  import prof_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       feat_ok,
  input  logic [1:0] lvl,
  input  logic       nv_trap,
  input  logic       l3_trap,
  input  logic       undef_prio,
  input  logic       undef_alt,
  output acc_res_e   res,
  output logic [5:0] cls
);
  always_comb begin
    res = ACC_UNDEF;
    if (feat_ok) begin
      unique case (lvl)
        2'd0: res = ACC_UNDEF;
        2'd1: res = nv_trap ? ACC_TRAP2 : ACC_UNDEF;
        2'd2: begin
          if (l3_trap && undef_prio)  res = ACC_UNDEF;
          else if (l3_trap)           res = undef_alt ? ACC_UNDEF : ACC_TRAP3;
          else                        res = ACC_DONE;
        end
        default: res = ACC_DONE;
      endcase
    end
  end

  always_comb begin
    cls = '0;
    if (res == ACC_TRAP2 || res == ACC_TRAP3) cls = TRAP_CLASS;
  end

  // R3
  lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == 2'd0 || !feat_ok) |-> res == ACC_UNDEF);
  // R6
  lvl3_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_ok && lvl == 2'd3) |-> res == ACC_DONE);
  // R4
  trap_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res == ACC_TRAP2 || res == ACC_TRAP3) |-> cls == TRAP_CLASS);
endmodule

// File: rtl/prof_fld_store.sv
module prof_fld_store
  import prof_ctl_pkg::*;
#(
  parameter int unsigned DATA_W     = 64,
  parameter bit          HAS_CNTEXT = 1'b1,
  parameter bit          HAS_PPTR   = 1'b1,
  parameter bit          HAS_EXC    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  function automatic logic [DATA_W-1:0] mk_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[B_PPTR]     = HAS_PPTR;
    m[B_KEXC]     = HAS_EXC;
    m[B_EXC+1]    = HAS_EXC;
    m[B_EXC]      = HAS_EXC;
    m[B_TSEL+1]   = HAS_CNTEXT;
    m[B_TSEL]     = 1'b1;
    m[B_TSEN]     = 1'b1;
    m[B_PAEN]     = 1'b1;
    m[B_CXEN]     = 1'b1;
    m[B_L2S]      = 1'b1;
    m[B_L0S]      = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] WMASK = mk_mask();

  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr_en) q_nxt = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= q_nxt;
  end

  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~WMASK) == '0);
endmodule

// File: rtl/prof_eff_calc.sv
module prof_eff_calc
  import prof_ctl_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  prof_fields_t st,
  input  logic [1:0]   l3_exc_ctl,
  input  logic         l2_present,
  input  logic         l2_enabled,
  input  logic         secure_nol2,
  input  logic         l2_owns_buf,
  input  logic [1:0]   own_ctl,
  output prof_fields_t eff
);
  logic l2_active;
  logic own_clr;

  assign l2_active = l2_present && l2_enabled;
  assign own_clr   = (own_ctl != 2'b00);

  always_comb begin
    eff = st;
    if (l3_exc_ctl == 2'b00)               eff.exc = 2'b00;
    else if (!l2_present || secure_nol2)   eff.exc = 2'b01;
    if (!l2_active) begin
      eff.paen = 1'b1;
      eff.tsel = 2'b01;
    end
    if (!l2_active || l2_owns_buf)         eff.pptr = 1'b1;
    if (own_clr) begin
      eff.l2s = 1'b0;
      eff.l0s = 1'b0;
    end
  end

  // R7
  exc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l3_exc_ctl == 2'b00) |-> eff.exc == 2'b00);
  // R9
  own_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_ctl != 2'b00) |-> (!eff.l2s && !eff.l0s));
  // R8
  pa_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l2_present && l2_enabled) |-> (eff.paen && eff.pptr));
endmodule

// File: rtl/prof_ctl_reg.sv
module prof_ctl_reg
  import prof_ctl_pkg::*;
#(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned LVL_W      = 2,
  parameter int unsigned CLS_W      = 6,
  parameter bit          HAS_CNTEXT = 1'b1,
  parameter bit          HAS_PPTR   = 1'b1,
  parameter bit          HAS_EXC    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [LVL_W-1:0]  req_lvl,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cfg_feat_present,
  input  logic              cfg_nv_trap,
  input  logic              cfg_l3_trap,
  input  logic              cfg_undef_prio,
  input  logic              cfg_undef_alt,
  input  logic [1:0]        cfg_l3_exc_ctl,
  input  logic              cfg_l2_present,
  input  logic              cfg_l2_enabled,
  input  logic              cfg_secure_nol2,
  input  logic              cfg_l2_owns_buf,
  input  logic [1:0]        cfg_own_ctl,
  output logic [1:0]        rsp_outcome,
  output logic [CLS_W-1:0]  rsp_class,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              eff_pptr,
  output logic              eff_kexc,
  output logic [1:0]        eff_exc,
  output logic [1:0]        eff_tsel,
  output logic              eff_tsen,
  output logic              eff_paen,
  output logic              eff_cxen,
  output logic              eff_l2spe,
  output logic              eff_l0spe
);
  acc_res_e          acc_res;
  logic [5:0]        acc_cls;
  logic              wr_en;
  logic [DATA_W-1:0] stored_q;
  logic [DATA_W-1:0] view_q;
  prof_fields_t      st_f;
  prof_fields_t      eff_f;

  prof_acc_chk u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .feat_ok    (cfg_feat_present),
    .lvl        (req_lvl),
    .nv_trap    (cfg_nv_trap),
    .l3_trap    (cfg_l3_trap),
    .undef_prio (cfg_undef_prio),
    .undef_alt  (cfg_undef_alt),
    .res        (acc_res),
    .cls        (acc_cls)
  );

  assign wr_en = req_valid && req_write && (acc_res == ACC_DONE);

  prof_fld_store #(
    .DATA_W     (DATA_W),
    .HAS_CNTEXT (HAS_CNTEXT),
    .HAS_PPTR   (HAS_PPTR),
    .HAS_EXC    (HAS_EXC)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wdata (req_wdata),
    .q     (stored_q)
  );

  always_comb begin
    view_q = stored_q;
    if (cfg_own_ctl != 2'b00) begin
      view_q[B_L2S] = 1'b0;
      view_q[B_L0S] = 1'b0;
    end
  end

  assign st_f = '{pptr: stored_q[B_PPTR], kexc: stored_q[B_KEXC],
                  exc: stored_q[B_EXC+1:B_EXC], tsel: stored_q[B_TSEL+1:B_TSEL],
                  tsen: stored_q[B_TSEN], paen: stored_q[B_PAEN],
                  cxen: stored_q[B_CXEN], l2s: stored_q[B_L2S], l0s: stored_q[B_L0S]};

  prof_eff_calc u_eff (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (st_f),
    .l3_exc_ctl  (cfg_l3_exc_ctl),
    .l2_present  (cfg_l2_present),
    .l2_enabled  (cfg_l2_enabled),
    .secure_nol2 (cfg_secure_nol2),
    .l2_owns_buf (cfg_l2_owns_buf),
    .own_ctl     (cfg_own_ctl),
    .eff         (eff_f)
  );

  assign rsp_outcome = acc_res;
  assign rsp_class   = CLS_W'(acc_cls);
  assign rsp_rdata   = (req_valid && !req_write && acc_res == ACC_DONE) ? view_q : '0;

  assign eff_pptr  = eff_f.pptr;
  assign eff_kexc  = eff_f.kexc;
  assign eff_exc   = eff_f.exc;
  assign eff_tsel  = eff_f.tsel;
  assign eff_tsen  = eff_f.tsen;
  assign eff_paen  = eff_f.paen;
  assign eff_cxen  = eff_f.cxen;
  assign eff_l2spe = eff_f.l2s;
  assign eff_l0spe = eff_f.l0s;

  // R11
  wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && rsp_outcome != 2'b00) |=> $stable(stored_q));
endmodule

// File: tb/sim_prof_ctl_reg.sv
module sim_prof_ctl_reg;
  localparam logic [63:0] MASK = 64'h0000_0000_0000_0FFB;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_lvl;
  logic [63:0] req_wdata;
  logic        cfg_feat_present, cfg_nv_trap, cfg_l3_trap, cfg_undef_prio, cfg_undef_alt;
  logic [1:0]  cfg_l3_exc_ctl, cfg_own_ctl;
  logic        cfg_l2_present, cfg_l2_enabled, cfg_secure_nol2, cfg_l2_owns_buf;
  logic [1:0]  rsp_outcome;
  logic [5:0]  rsp_class;
  logic [63:0] rsp_rdata;
  logic        eff_pptr, eff_kexc, eff_tsen, eff_paen, eff_cxen, eff_l2spe, eff_l0spe;
  logic [1:0]  eff_exc, eff_tsel;

  always #4 clk = ~clk;

  prof_ctl_reg u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_lvl(req_lvl), .req_wdata(req_wdata), .cfg_feat_present(cfg_feat_present),
    .cfg_nv_trap(cfg_nv_trap), .cfg_l3_trap(cfg_l3_trap), .cfg_undef_prio(cfg_undef_prio),
    .cfg_undef_alt(cfg_undef_alt), .cfg_l3_exc_ctl(cfg_l3_exc_ctl),
    .cfg_l2_present(cfg_l2_present), .cfg_l2_enabled(cfg_l2_enabled),
    .cfg_secure_nol2(cfg_secure_nol2), .cfg_l2_owns_buf(cfg_l2_owns_buf),
    .cfg_own_ctl(cfg_own_ctl), .rsp_outcome(rsp_outcome), .rsp_class(rsp_class),
    .rsp_rdata(rsp_rdata), .eff_pptr(eff_pptr), .eff_kexc(eff_kexc), .eff_exc(eff_exc),
    .eff_tsel(eff_tsel), .eff_tsen(eff_tsen), .eff_paen(eff_paen), .eff_cxen(eff_cxen),
    .eff_l2spe(eff_l2spe), .eff_l0spe(eff_l0spe)
  );

  typedef struct {
    string       tag;
    logic [1:0]  res;
    logic [5:0]  cls;
    logic [63:0] rdata;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_err = 0;
  logic [63:0] mdl;
  bit          done = 1'b0;

  function automatic logic [1:0] exp_res(input logic [1:0] lvl);
    if (!cfg_feat_present || lvl == 2'd0) return 2'b01;
    if (lvl == 2'd1) return cfg_nv_trap ? 2'b10 : 2'b01;
    if (lvl == 2'd2) begin
      if (cfg_l3_trap && cfg_undef_prio) return 2'b01;
      if (cfg_l3_trap) return cfg_undef_alt ? 2'b01 : 2'b11;
      return 2'b00;
    end
    return 2'b00;
  endfunction

  function automatic logic [11:0] exp_eff();
    logic       act;
    logic [1:0] e;
    act = cfg_l2_present && cfg_l2_enabled;
    if (cfg_l3_exc_ctl == 2'b00) e = 2'b00;
    else if (!cfg_l2_present || cfg_secure_nol2) e = 2'b01;
    else e = mdl[9:8];
    return {(!act || cfg_l2_owns_buf) ? 1'b1 : mdl[11], mdl[10], e,
            act ? mdl[7:6] : 2'b01, mdl[5], act ? mdl[4] : 1'b1, mdl[3],
            (cfg_own_ctl != 0) ? 1'b0 : mdl[1], (cfg_own_ctl != 0) ? 1'b0 : mdl[0]};
  endfunction

  task automatic acc(input bit wr, input logic [1:0] lvl, input logic [63:0] d, input string tag);
    exp_t        e;
    logic [63:0] vq;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_lvl = lvl; req_wdata = d;
    e.tag = tag;
    e.res = exp_res(lvl);
    e.cls = (e.res[1]) ? 6'h18 : 6'h00;
    vq = mdl;
    if (cfg_own_ctl != 0) vq[1:0] = 2'b00;
    e.rdata = (!wr && e.res == 2'b00) ? vq : 64'h0;
    sb.push_back(e);
    if (wr && e.res == 2'b00) mdl = d & MASK;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_eff(input string tag);
    logic [11:0] got, exp;
    @(negedge clk);
    #3;
    exp = exp_eff();
    got = {eff_pptr, eff_kexc, eff_exc, eff_tsel, eff_tsen, eff_paen, eff_cxen, eff_l2spe, eff_l0spe};
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: effective fields actual %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops one expected item per presented request
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (req_valid) begin
        exp_t e;
        n_chk++;
        if (sb.size() == 0) begin
          n_err++;
          $display("FAIL R12: response with empty scoreboard, actual %h expected none", rsp_outcome);
        end else begin
          e = sb.pop_front();
          if (rsp_outcome !== e.res || rsp_class !== e.cls || rsp_rdata !== e.rdata) begin
            n_err++;
            $display("FAIL %s: actual res=%b cls=%h rd=%h expected res=%b cls=%h rd=%h",
                     e.tag, rsp_outcome, rsp_class, rsp_rdata, e.res, e.cls, e.rdata);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_lvl = 2'd0; req_wdata = '0;
    cfg_feat_present = 1'b1; cfg_nv_trap = 1'b0; cfg_l3_trap = 1'b0;
    cfg_undef_prio = 1'b0; cfg_undef_alt = 1'b0; cfg_l3_exc_ctl = 2'b10;
    cfg_l2_present = 1'b1; cfg_l2_enabled = 1'b1; cfg_secure_nol2 = 1'b0;
    cfg_l2_owns_buf = 1'b0; cfg_own_ctl = 2'b00;
    mdl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk_eff("R12 reset effective");
    acc(1'b0, 2'd3, 64'h0, "R12 reset read");
    acc(1'b1, 2'd3, '1, "R1 write ones");
    acc(1'b0, 2'd2, 64'h0, "R1 R2 read masked ones");
    acc(1'b1, 2'd2, 64'hDEAD_0000_0000_0A65, "R2 write pattern");
    acc(1'b0, 2'd3, 64'h0, "R2 read pattern");
    chk_eff("R2 effective follows store");
    acc(1'b1, 2'd0, 64'hFFF, "R3 level0 write");
    acc(1'b0, 2'd3, 64'h0, "R11 after level0 write");
    cfg_feat_present = 1'b0;
    acc(1'b1, 2'd3, 64'h0, "R3 feature absent");
    cfg_feat_present = 1'b1;
    acc(1'b1, 2'd1, 64'h0, "R4 level1 undefined");
    cfg_nv_trap = 1'b1;
    acc(1'b1, 2'd1, 64'h0, "R4 level1 trap2");
    acc(1'b0, 2'd3, 64'h0, "R11 after trapped write");
    cfg_nv_trap = 1'b0;
    cfg_l3_trap = 1'b1; cfg_undef_prio = 1'b1;
    acc(1'b1, 2'd2, 64'h0, "R5 prio undefined");
    cfg_undef_prio = 1'b0;
    acc(1'b1, 2'd2, 64'h0, "R5 trap3");
    cfg_undef_alt = 1'b1;
    acc(1'b1, 2'd2, 64'h0, "R5 alt undefined");
    cfg_l3_trap = 1'b0;
    acc(1'b1, 2'd2, 64'h0000_0000_0000_0B5B, "R5 alt only completes");
    acc(1'b0, 2'd2, 64'h0, "R5 read after complete");
    cfg_undef_alt = 1'b0;
    acc(1'b1, 2'd3, 64'h0000_0000_0000_0FFB, "R6 level3 write");
    cfg_l3_exc_ctl = 2'b00;
    chk_eff("R7 exception forced off");
    cfg_l3_exc_ctl = 2'b11; cfg_secure_nol2 = 1'b1;
    chk_eff("R7 secure no level2");
    cfg_secure_nol2 = 1'b0; cfg_l2_present = 1'b0;
    chk_eff("R7 R8 R10 level2 absent");
    cfg_l2_present = 1'b1; cfg_l2_enabled = 1'b0;
    chk_eff("R8 R10 level2 disabled");
    acc(1'b1, 2'd3, 64'h0000_0000_0000_0000, "R10 write zero");
    chk_eff("R8 R10 forced values over zero");
    acc(1'b0, 2'd3, 64'h0, "R10 direct read stored");
    cfg_l2_enabled = 1'b1; cfg_l2_owns_buf = 1'b1;
    chk_eff("R8 level2 owns buffer");
    cfg_l2_owns_buf = 1'b0;
    acc(1'b1, 2'd2, 64'h0000_0000_0000_0003, "R9 write sampling bits");
    cfg_own_ctl = 2'b01;
    acc(1'b0, 2'd2, 64'h0, "R9 read cleared");
    chk_eff("R9 effective cleared");
    cfg_own_ctl = 2'b00;
    acc(1'b0, 2'd2, 64'h0, "R9 read restored");
    chk_eff("R9 effective restored");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R12: %0d responses missing, expected 0", sb.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule